// File: doc/BRIEF.md
# SPI FIFO Flag and Request Controller

This block sits between the CPU register port of an SPI peripheral and its shift engine. It holds one transmit queue and one receive queue of bytes. Software writes bytes into the transmit queue and reads bytes from the receive queue. The shift engine consumes transmit bytes with a pop strobe and deposits received bytes with a push strobe. Serial shifting, clock generation and chip select belong to neighbouring logic and appear here only as those strobes.

Around the two queues the block derives the level flags, the two overflow flags and four interrupt lines. It also produces one DMA request per direction. A DMA enable takes precedence over the matching interrupt. A clear-mode control bit decides how the interrupts behave. When it is low, each interrupt tracks its condition. When it is high, each interrupt is latched and must be acknowledged by writing a one. A single mode enable switches the whole queueing function on or off. Switching it off flushes both queues.

Top module: `spi_fifo_ctrl`

## Requirements
- R1: Each queue holds DEPTH=8 bytes and delivers them first-in first-out. CPU writes and engine pushes are accepted only while `fifo_en` is 1; otherwise they are ignored.
- R2: `rx_empty`/`tx_empty` are 1 exactly when the queue holds no byte. `rx_full`/`tx_full` are 1 exactly when it holds 8 bytes. The empty flags read 1 and the full flags read 0 while `fifo_en` is 0.
- R3: `rx_near_full` is 1 when the receive queue holds 6 or more bytes. `tx_near_empty` is 1 when the transmit queue holds 2 or fewer bytes. Both read 0 while `fifo_en` is 0.
- R4: `dma_rx_req` equals `fifo_en & rx_dma_en & ~rx_empty`, so it stays high until the receive queue is drained.
- R5: `dma_tx_req` equals `fifo_en & tx_dma_en & ~tx_full`, so it stays high until the transmit queue fills.
- R6: Each interrupt has a condition. For `irq_rx_full` it is receive queue not empty with `rx_irq_en`=1 and `rx_dma_en`=0. For `irq_tx_empty` it is transmit queue not full with `tx_irq_en`=1 and `tx_dma_en`=0. For `irq_rx_nfull` it is `rx_near_full` with `rx_irq_en`=1. For `irq_tx_nempty` it is `tx_near_empty` with `tx_irq_en`=1. An interrupt line responds one cycle after its condition.
- R7: With `clr_mode`=0, each interrupt line follows its condition one cycle later, and acknowledge writes have no effect.
- R8: With `clr_mode`=1, an interrupt sets when its condition rises and holds until a cycle with `ack_wr`=1 and its acknowledge bit set. The acknowledge bits are: `ack_bits[0]` for receive-full, `[1]` for transmit-empty, `[2]` for receive-nearly-full and `[3]` for transmit-nearly-empty. A rise in the same cycle wins over the acknowledge.
- R9: A push into a full receive queue sets `rx_ovf`. A CPU write into a full transmit queue sets `tx_ovf`. The byte is dropped and the queue contents and order are unchanged.
- R10: The overflow flags stay set until a cycle with `ovf_clr`=1. A new overflow in that same cycle keeps the flag set.
- R11: Dropping `fifo_en` flushes both queues. In the following cycle all flags, interrupts and requests are back at their reset values.
- R12: A CPU read of an empty receive queue, or an engine pop of an empty transmit queue, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | Queue mode enable; 0 flushes |
| clr_mode | input | 1 | 1 = interrupts latched, cleared by acknowledge |
| rx_dma_en | input | 1 | Receive DMA enable |
| tx_dma_en | input | 1 | Transmit DMA enable |
| rx_irq_en | input | 1 | Receive interrupt enable |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| cpu_wr | input | 1 | CPU byte write into transmit queue |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rd | input | 1 | CPU read strobe, removes the receive head |
| cpu_rdata | output | 8 | Receive queue head |
| ack_wr | input | 1 | Acknowledge write strobe |
| ack_bits | input | 4 | Write-one-to-clear acknowledge bits |
| ovf_clr | input | 1 | Clears both overflow flags |
| eng_tx_pop | input | 1 | Engine takes the transmit head |
| eng_tx_data | output | 8 | Transmit queue head |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_near_empty | output | 1 | Transmit level at or below 2 |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_near_full | output | 1 | Receive level at or above 6 |
| tx_ovf | output | 1 | Transmit overflow flag |
| rx_ovf | output | 1 | Receive overflow flag |
| irq_rx_full | output | 1 | Receive-data interrupt |
| irq_tx_empty | output | 1 | Transmit-space interrupt |
| irq_rx_nfull | output | 1 | Receive nearly-full interrupt |
| irq_tx_nempty | output | 1 | Transmit nearly-empty interrupt |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
The hardest case to reach is the latched-interrupt case. There, the condition has already gone away, so the line is held only by its latch. An acknowledge must then clear exactly one line and leave its neighbours untouched. The stimulus gets there in three steps. First it raises the receive condition by pushing a byte. Then it drains the queue so the condition falls. Finally it sends acknowledges, first with a wrong bit and then with the right one. Overflow is reached by filling a queue to eight bytes and offering a ninth. The scoreboard then confirms that the eight stored bytes still come out in order.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
   localparam int IRQ_N         = 4;
   localparam int IRQ_RX_FULL   = 0;
   localparam int IRQ_TX_EMPTY  = 1;
   localparam int IRQ_RX_NFULL  = 2;
   localparam int IRQ_TX_NEMPTY = 3;
endpackage

// File: rtl/sfc_fifo.sv
module sfc_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DATA_W-1:0] din,
   input  logic              pop,
   output logic [DATA_W-1:0] dout,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic              full,
   output logic              empty,
   output logic              ovf_evt
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr;
   logic              wr_ok, rd_ok;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign wr_ok   = push && !full;
   assign rd_ok   = pop && !empty;
   assign ovf_evt = push && full;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
         if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
         count <= count + CW'(wr_ok) - CW'(rd_ok);
      end
   end

   always_ff @(posedge clk) begin
      if (wr_ok && !flush) mem[wr_ptr] <= din;
   end
endmodule

// File: rtl/sfc_irq_flag.sv
module sfc_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic clr_mode,
   input  logic cond,
   input  logic ack,
   output logic flag
);
   logic cond_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag   <= 1'b0;
         cond_q <= 1'b0;
      end else if (!enable) begin
         flag   <= 1'b0;
         cond_q <= 1'b0;
      end else begin
         cond_q <= cond;
         if (clr_mode) flag <= (flag && !ack) || (cond && !cond_q);
         else          flag <= cond;
      end
   end
endmodule

// File: rtl/spi_fifo_ctrl.sv
module spi_fifo_ctrl
   import spi_fifo_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int DEPTH      = 8,
   parameter int NEAR_FULL  = 6,
   parameter int NEAR_EMPTY = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_en,
   input  logic              clr_mode,
   input  logic              rx_dma_en,
   input  logic              tx_dma_en,
   input  logic              rx_irq_en,
   input  logic              tx_irq_en,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              cpu_rd,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              ack_wr,
   input  logic [IRQ_N-1:0]  ack_bits,
   input  logic              ovf_clr,
   input  logic              eng_tx_pop,
   output logic [DATA_W-1:0] eng_tx_data,
   input  logic              eng_rx_push,
   input  logic [DATA_W-1:0] eng_rx_data,
   output logic              tx_empty,
   output logic              tx_full,
   output logic              tx_near_empty,
   output logic              rx_empty,
   output logic              rx_full,
   output logic              rx_near_full,
   output logic              tx_ovf,
   output logic              rx_ovf,
   output logic              irq_rx_full,
   output logic              irq_tx_empty,
   output logic              irq_rx_nfull,
   output logic              irq_tx_nempty,
   output logic              dma_rx_req,
   output logic              dma_tx_req
);
   localparam int CW = $clog2(DEPTH+1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH-1)) != 0)
         $error("DEPTH must be a power of two and at least 2");
      if (NEAR_FULL < 1 || NEAR_FULL > DEPTH)
         $error("NEAR_FULL out of range");
      if (NEAR_EMPTY < 0 || NEAR_EMPTY >= DEPTH)
         $error("NEAR_EMPTY out of range");
   endgenerate

   logic [CW-1:0]    tx_cnt, rx_cnt;
   logic             tx_full_i, tx_empty_i, rx_full_i, rx_empty_i;
   logic             tx_ovf_evt, rx_ovf_evt;
   logic             flush;
   logic [IRQ_N-1:0] cond, flags;

   assign flush = !fifo_en;

   sfc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_tx_q (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .push(cpu_wr && fifo_en), .din(cpu_wdata),
      .pop(eng_tx_pop && fifo_en), .dout(eng_tx_data),
      .count(tx_cnt), .full(tx_full_i), .empty(tx_empty_i),
      .ovf_evt(tx_ovf_evt)
   );

   sfc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_rx_q (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .push(eng_rx_push && fifo_en), .din(eng_rx_data),
      .pop(cpu_rd && fifo_en), .dout(cpu_rdata),
      .count(rx_cnt), .full(rx_full_i), .empty(rx_empty_i),
      .ovf_evt(rx_ovf_evt)
   );

   assign tx_empty      = !fifo_en || tx_empty_i;
   assign rx_empty      = !fifo_en || rx_empty_i;
   assign tx_full       = fifo_en && tx_full_i;
   assign rx_full       = fifo_en && rx_full_i;
   assign tx_near_empty = fifo_en && (tx_cnt <= CW'(NEAR_EMPTY));
   assign rx_near_full  = fifo_en && (rx_cnt >= CW'(NEAR_FULL));

   assign dma_rx_req = fifo_en && rx_dma_en && !rx_empty;
   assign dma_tx_req = fifo_en && tx_dma_en && !tx_full;

   always_comb begin
      cond                = '0;
      cond[IRQ_RX_FULL]   = !rx_empty && rx_irq_en && !rx_dma_en;
      cond[IRQ_TX_EMPTY]  = fifo_en && !tx_full && tx_irq_en && !tx_dma_en;
      cond[IRQ_RX_NFULL]  = rx_near_full && rx_irq_en;
      cond[IRQ_TX_NEMPTY] = tx_near_empty && tx_irq_en;
   end

   generate
      for (genvar g = 0; g < IRQ_N; g++) begin : g_irq
         sfc_irq_flag i_flag (
            .clk(clk), .rst_n(rst_n), .enable(fifo_en),
            .clr_mode(clr_mode), .cond(cond[g]),
            .ack(ack_wr && ack_bits[g]), .flag(flags[g])
         );
      end
   endgenerate

   assign irq_rx_full   = flags[IRQ_RX_FULL];
   assign irq_tx_empty  = flags[IRQ_TX_EMPTY];
   assign irq_rx_nfull  = flags[IRQ_RX_NFULL];
   assign irq_tx_nempty = flags[IRQ_TX_NEMPTY];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_ovf <= 1'b0;
         rx_ovf <= 1'b0;
      end else if (!fifo_en) begin
         tx_ovf <= 1'b0;
         rx_ovf <= 1'b0;
      end else begin
         tx_ovf <= tx_ovf_evt || (tx_ovf && !ovf_clr);
         rx_ovf <= rx_ovf_evt || (rx_ovf && !ovf_clr);
      end
   end
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker (
   input logic clk,
   input logic rst_n,
   input logic fifo_en,
   input logic clr_mode,
   input logic rx_dma_en,
   input logic tx_irq_en,
   input logic cpu_rd,
   input logic ovf_clr,
   input logic eng_rx_push,
   input logic rx_empty,
   input logic rx_full,
   input logic tx_ovf,
   input logic rx_ovf,
   input logic irq_rx_full,
   input logic irq_tx_empty,
   input logic irq_rx_nfull,
   input logic irq_tx_nempty,
   input logic dma_rx_req
);
   AST_RX_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_en && rx_full && eng_rx_push |=> rx_ovf); // R9
   AST_RX_FULL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_en && rx_full && eng_rx_push && !cpu_rd |=> rx_full || !fifo_en); // R9
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_en && rx_ovf && !ovf_clr |=> rx_ovf); // R10
   AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |=> !rx_ovf && !tx_ovf && !irq_rx_full && !irq_tx_empty
                   && !irq_rx_nfull && !irq_tx_nempty); // R11
   AST_DMA_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_dma_en && !clr_mode |=> !irq_rx_full); // R6
   AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_en && !clr_mode && !tx_irq_en |=> !irq_tx_empty && !irq_tx_nempty); // R7
   AST_RX_DMA_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      dma_rx_req |-> !rx_empty); // R4
   AST_EMPTY_FULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_empty && rx_full)); // R2
endmodule

bind spi_fifo_ctrl sfc_checker i_sfc_checker (.*);

// File: tb/test_spi_fifo_ctrl.sv
module test_spi_fifo_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fifo_en = 0, clr_mode = 0, rx_dma_en = 0, tx_dma_en = 0;
   logic       rx_irq_en = 0, tx_irq_en = 0;
   logic       cpu_wr = 0, cpu_rd = 0, ack_wr = 0, ovf_clr = 0;
   logic [7:0] cpu_wdata = 0, eng_rx_data = 0;
   logic [3:0] ack_bits = 0;
   logic       eng_tx_pop = 0, eng_rx_push = 0;
   logic [7:0] cpu_rdata, eng_tx_data;
   logic tx_empty, tx_full, tx_near_empty, rx_empty, rx_full, rx_near_full;
   logic tx_ovf, rx_ovf, irq_rx_full, irq_tx_empty, irq_rx_nfull, irq_tx_nempty;
   logic dma_rx_req, dma_tx_req;

   int   n_chk = 0, n_fail = 0;
   bit   done = 0;
   logic [7:0] tx_q[$], rx_q[$];

   always #5 clk = ~clk;

   spi_fifo_ctrl i_spi_fifo_ctrl (.*);

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic eq(input string tag, input int act, input int exp);
      chk(act == exp, tag, act, exp);
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic tx_write(input logic [7:0] b, input bit accept);
      cpu_wr = 1; cpu_wdata = b;
      if (accept) tx_q.push_back(b);
      tick(); cpu_wr = 0;
   endtask

   task automatic rx_push(input logic [7:0] b, input bit accept);
      eng_rx_push = 1; eng_rx_data = b;
      if (accept) rx_q.push_back(b);
      tick(); eng_rx_push = 0;
   endtask

   task automatic tx_pop();
      eng_tx_pop = 1; tick(); eng_tx_pop = 0;
   endtask

   task automatic rx_read();
      cpu_rd = 1; tick(); cpu_rd = 0;
   endtask

   task automatic ack(input logic [3:0] bits);
      ack_wr = 1; ack_bits = bits; tick(); ack_wr = 0; ack_bits = 0;
   endtask

   // Monitor: compares each byte the design hands out with the scoreboard
   always @(negedge clk) begin
      if (fifo_en && eng_tx_pop && !tx_empty) begin
         if (tx_q.size() == 0) chk(0, "R1 tx unexpected byte", eng_tx_data, -1);
         else eq("R1 tx order", eng_tx_data, tx_q.pop_front());
      end
      if (fifo_en && cpu_rd && !rx_empty) begin
         if (rx_q.size() == 0) chk(0, "R1 rx unexpected byte", cpu_rdata, -1);
         else eq("R9 rx order", cpu_rdata, rx_q.pop_front());
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      tick(); tick();
      eq("R11 reset rx_empty", rx_empty, 1);
      eq("R11 reset tx_empty", tx_empty, 1);
      eq("R11 reset dma", {dma_rx_req, dma_tx_req}, 0);
      eq("R11 reset irq", {irq_rx_full, irq_tx_empty, irq_rx_nfull, irq_tx_nempty}, 0);
      eq("R11 reset ovf", {rx_ovf, tx_ovf}, 0);
      rst_n = 1; tick();

      // R1: ignored while disabled
      tx_write(8'h11, 0);
      eq("R1 write ignored when disabled", tx_empty, 1);
      rx_push(8'h22, 0);
      eq("R1 push ignored when disabled", rx_empty, 1);

      fifo_en = 1; tick();
      eq("R3 tx_near_empty at 0", tx_near_empty, 1);
      for (int i = 0; i < 8; i++) begin
         tx_write(8'hA0 + 8'(i), 1);
         if (i == 1) eq("R3 tx_near_empty at 2", tx_near_empty, 1);
         if (i == 2) eq("R3 tx_near_empty at 3", tx_near_empty, 0);
         if (i == 6) eq("R2 tx_full at 7", tx_full, 0);
      end
      eq("R2 tx_full at 8", tx_full, 1);
      tx_write(8'hEE, 0);
      eq("R9 tx_ovf set", tx_ovf, 1);
      eq("R9 tx still full", tx_full, 1);
      tick(); tick();
      eq("R10 tx_ovf sticky", tx_ovf, 1);
      ovf_clr = 1; tick(); ovf_clr = 0;
      eq("R10 tx_ovf cleared", tx_ovf, 0);

      tx_dma_en = 1; #1;
      eq("R5 dma_tx_req low when full", dma_tx_req, 0);
      tx_pop();
      eq("R5 dma_tx_req high when not full", dma_tx_req, 1);
      for (int i = 0; i < 7; i++) tx_pop();
      eq("R2 tx_empty after drain", tx_empty, 1);
      tx_dma_en = 0;
      tx_pop();
      eq("R12 pop of empty tx", tx_empty, 1);
      tx_write(8'h5A, 1);
      tx_pop();
      eq("R12 tx scoreboard drained", tx_q.size(), 0);

      // receive side with DMA
      rx_dma_en = 1;
      for (int i = 0; i < 8; i++) begin
         rx_push(8'h30 + 8'(i), 1);
         if (i == 0) eq("R4 dma_rx_req after first byte", dma_rx_req, 1);
         if (i == 4) eq("R3 rx_near_full at 5", rx_near_full, 0);
         if (i == 5) eq("R3 rx_near_full at 6", rx_near_full, 1);
      end
      eq("R2 rx_full at 8", rx_full, 1);
      rx_push(8'hFF, 0);
      eq("R9 rx_ovf set", rx_ovf, 1);
      eq("R6 no irq while rx DMA", irq_rx_full, 0);
      for (int i = 0; i < 7; i++) rx_read();
      eq("R4 dma_rx_req held with data", dma_rx_req, 1);
      rx_read();
      eq("R4 dma_rx_req drops when empty", dma_rx_req, 0);
      rx_read();
      eq("R12 read of empty rx", rx_empty, 1);
      ovf_clr = 1; tick(); ovf_clr = 0;
      rx_dma_en = 0;

      // interrupts, clr_mode = 0
      rx_irq_en = 1;
      rx_push(8'h77, 1);
      tick();
      eq("R6 irq_rx_full raised", irq_rx_full, 1);
      rx_dma_en = 1; tick();
      eq("R6 DMA overrides irq", irq_rx_full, 0);
      rx_dma_en = 0; tick();
      eq("R6 irq back", irq_rx_full, 1);
      ack(4'b0001);
      eq("R7 ack ignored in level mode", irq_rx_full, 1);
      rx_read(); tick();
      eq("R7 irq follows condition away", irq_rx_full, 0);
      for (int i = 0; i < 6; i++) rx_push(8'h40 + 8'(i), 1);
      tick();
      eq("R6 irq_rx_nfull raised", irq_rx_nfull, 1);
      rx_read(); tick();
      eq("R7 irq_rx_nfull falls", irq_rx_nfull, 0);
      for (int i = 0; i < 5; i++) rx_read();

      // interrupts, clr_mode = 1
      clr_mode = 1; tick();
      rx_push(8'h99, 1);
      tick();
      eq("R8 latched irq set", irq_rx_full, 1);
      rx_read(); tick();
      eq("R8 latch holds after condition gone", irq_rx_full, 1);
      ack(4'b0010);
      eq("R8 wrong ack bit ignored", irq_rx_full, 1);
      ack(4'b0001);
      eq("R8 ack bit0 clears", irq_rx_full, 0);
      tx_irq_en = 1; tick();
      eq("R8 irq_tx_empty set on rise", irq_tx_empty, 1);
      eq("R8 irq_tx_nempty set on rise", irq_tx_nempty, 1);
      ack(4'b0010);
      eq("R8 ack bit1 clears tx_empty irq", irq_tx_empty, 0);
      eq("R8 bit1 leaves tx_nempty", irq_tx_nempty, 1);
      ack(4'b1000);
      eq("R8 ack bit3 clears tx_nempty irq", irq_tx_nempty, 0);
      tx_irq_en = 0; rx_irq_en = 0; clr_mode = 0;

      // flush
      for (int i = 0; i < 3; i++) tx_write(8'hC0 + 8'(i), 1);
      for (int i = 0; i < 8; i++) rx_push(8'hD0 + 8'(i), 1);
      rx_push(8'hDD, 0);
      eq("R9 rx_ovf before flush", rx_ovf, 1);
      fifo_en = 0; tick();
      eq("R11 flush rx_empty", rx_empty, 1);
      eq("R11 flush tx_empty", tx_empty, 1);
      eq("R11 flush ovf", {rx_ovf, tx_ovf}, 0);
      eq("R11 flush dma", {dma_rx_req, dma_tx_req}, 0);
      tx_q.delete(); rx_q.delete();
      fifo_en = 1; tick();
      eq("R11 queues empty after re-enable", {rx_empty, tx_empty}, 3);
      tx_write(8'h3C, 1);
      tx_pop();
      eq("R1 tx scoreboard drained after flush", tx_q.size(), 0);
      tick();
      finish_run();
   end
endmodule